// File: doc/BRIEF.md
# SMBus Information ROM Target

This block is a two-wire SMBus target that exposes a 256-byte byte-addressed space. The lower half holds a fixed information image that is built into the logic as a constant. The upper half is a writable scratch area. The block samples SCL and SDA, finds START and STOP conditions, and shifts bytes in and out one bit at a time. It drives the data line low only through an output-enable signal, which is the open-drain model. Two transaction types are served. Write Byte sends the address, then an offset, then one data byte. Read Byte sends the address and an offset, then a repeated START with the read address, after which the target returns one byte.

The 7-bit target address is the fixed prefix 1010 followed by three strap inputs. The image begins with a header. Pointers in the header locate each data section. Every section is stored as a length byte, then that many data bytes, then a checksum byte. A checksum engine can be started on any section and reports whether the section sums correctly or is absent.

Top module: `smb_info_rom`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {1010, strap_i[2:0]}, and bit 0 is the direction (0 write, 1 read). On any other address it leaves SDA released and ignores the bus until the next START. Every command offset 00h–FFh is acknowledged.
- R2: A Write Byte to an offset from 80h to FFh is acknowledged on all three bytes, and the data is stored there. A later Read Byte of that offset returns it.
- R3: A Write Byte to an offset from 00h to 7Fh is acknowledged on all three bytes. The data byte is discarded, and the location keeps its image value.
- R4: In Read Byte, the target drives the addressed byte MSB first, one bit per SCL clock, and changes SDA only while SCL is low. It releases SDA before the controller's NACK clock and returns to idle after that clock.
- R5: A START anywhere resets the bit counter and begins a new address byte. A STOP anywhere returns the target to idle. An interrupted Write Byte stores nothing.
- R6: Image layout. Offset 00h holds 01h. Offsets 01h–04h hold the pointers for sections 0–3, which are 10h, 20h, 80h and 00h. Section 0 holds the bytes 03 AA 44 5C B6 from offset 10h. Section 1 holds the bytes 04 11 22 33 44 56 from offset 20h. Every other image byte reads FFh.
- R7: The checksum engine is started by chk_start_i with a section index. It raises chk_busy_o in the next cycle. chk_done_o pulses for one cycle in the cycle that chk_busy_o falls. chk_valid_o is set when the data bytes plus the checksum byte sum to 00h modulo 256.
- R8: A section whose header pointer is 00h is reported with chk_absent_o = 1 and chk_valid_o = 0.
- R9: sda_oe_o rises only while SCL is low. It is released at the SCL fall that ends an acknowledge clock or the last data bit.
- R10: After reset, sda_oe_o, chk_busy_o, chk_done_o, chk_valid_o and chk_absent_o are 0, and every scratch byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SCL and SDA are oversampled |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| strap_i | input | 3 | Low three bits of the target address |
| chk_start_i | input | 1 | Starts a section check (ignored while busy) |
| chk_sec_i | input | 2 | Index of the section to check |
| chk_busy_o | output | 1 | Check in progress |
| chk_done_o | output | 1 | One-cycle pulse when a check finishes |
| chk_valid_o | output | 1 | Last checked section summed to zero |
| chk_absent_o | output | 1 | Last checked section had a null pointer |

## Verification
The assertions check several rules on every cycle. The data-line enable may only rise while SCL is low. A START always leaves the line released. The check engine's start, busy and done signals must follow their order, and an absent section can never be flagged valid. Other behaviour shows only at the bus, so the bench's transactions must show it. This covers address matching against the straps, stored scratch writes, discarded writes to the image, MSB-first read data, and aborts caused by a STOP or a repeated START in mid-byte. The checksum verdicts on intact and corrupted sections are also shown this way.

// File: rtl/smb_info_pkg.sv
package smb_info_pkg;
  localparam int          ADDR_W     = 8;
  localparam int          ROM_DEPTH  = 128;
  localparam int          SEC_W      = 2;
  localparam logic [3:0]  DEV_PREFIX = 4'b1010;
  localparam logic [7:0]  HDR_PTR0   = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_CMD, S_ACK_C, S_WDAT, S_ACK_W, S_TX, S_MACK
  } bus_st_e;

  typedef enum logic [1:0] {C_IDLE, C_PTR, C_LEN, C_SUM} chk_st_e;

  function automatic logic [7:0] neg_sum4(input logic [7:0] b0, b1, b2, b3);
    return 8'(8'h00 - (b0 + b1 + b2 + b3));
  endfunction

  // fixed information image
  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    logic [7:0] d;
    d = 8'hFF;
    case (a)
      8'h00: d = 8'h01;
      8'h01: d = 8'h10;
      8'h02: d = 8'h20;
      8'h03: d = 8'h80;
      8'h04: d = 8'h00;
      8'h10: d = 8'h03;
      8'h11: d = 8'hAA;
      8'h12: d = 8'h44;
      8'h13: d = 8'h5C;
      8'h14: d = 8'hB6;
      8'h20: d = 8'h04;
      8'h21, 8'h22, 8'h23, 8'h24: d = 8'((a - 8'h20) * 8'h11);
      8'h25: d = neg_sum4(8'h11, 8'h22, 8'h33, 8'h44);
      default: d = 8'hFF;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = !scl_q && scl_s;
  assign scl_fall_o = scl_q && !scl_s;
  assign start_o    = scl_q && scl_s && sda_q && !sda_s;
  assign stop_o     = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/smb_info_mem.sv
module smb_info_mem
  import smb_info_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int ROM_D = ROM_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] a_addr_i,
  output logic [7:0]    a_data_o,
  input  logic [AW-1:0] b_addr_i,
  output logic [7:0]    b_data_o
);
  localparam int SCR_D  = (1 << AW) - ROM_D;
  localparam int SCR_AW = $clog2(SCR_D);

  logic [7:0]    scr [SCR_D];
  logic [AW-1:0] w_rel, a_rel, b_rel;
  logic          w_hit;

  assign w_rel = waddr_i - AW'(ROM_D);
  assign a_rel = a_addr_i - AW'(ROM_D);
  assign b_rel = b_addr_i - AW'(ROM_D);
  assign w_hit = we_i && (waddr_i >= AW'(ROM_D));  // image writes dropped

  for (genvar g = 0; g < SCR_D; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         scr[g] <= 8'h00;
      else if (w_hit && w_rel[SCR_AW-1:0] == SCR_AW'(g))   scr[g] <= wdata_i;
    end
  end

  assign a_data_o = (a_addr_i < AW'(ROM_D)) ? rom_byte(8'(a_addr_i)) : scr[a_rel[SCR_AW-1:0]];
  assign b_data_o = (b_addr_i < AW'(ROM_D)) ? rom_byte(8'(b_addr_i)) : scr[b_rel[SCR_AW-1:0]];
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_info_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    strap_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] offset_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);
  bus_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic       rw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sr       <= '0;
      rw       <= 1'b0;
      offset_o <= '0;
      we_o     <= 1'b0;
      wdata_o  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st <= S_ADDR; cnt <= '0; sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st <= S_IDLE; cnt <= '0; sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise_i && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sr[7:1] == {DEV_PREFIX, strap_i}) begin
                  rw <= sr[0]; sda_oe_o <= 1'b1; st <= S_ACK_A;
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_CMD) begin
                offset_o <= AW'(sr); sda_oe_o <= 1'b1; st <= S_ACK_C;
              end else begin
                wdata_o <= sr; we_o <= 1'b1; sda_oe_o <= 1'b1; st <= S_ACK_W;
              end
            end
          end
          S_ACK_A: if (scl_fall_i) begin
            if (rw) begin
              sr <= rd_data_i; sda_oe_o <= !rd_data_i[7]; st <= S_TX;
            end else begin
              sda_oe_o <= 1'b0; st <= S_CMD;
            end
          end
          S_ACK_C: if (scl_fall_i) begin sda_oe_o <= 1'b0; st <= S_WDAT; end
          S_ACK_W: if (scl_fall_i) begin sda_oe_o <= 1'b0; st <= S_IDLE; end
          S_TX: begin
            if (scl_rise_i) cnt <= cnt + 4'd1;
            else if (scl_fall_i) begin
              if (cnt == 4'd8) begin
                sda_oe_o <= 1'b0; cnt <= '0; st <= S_MACK;
              end else begin
                sr <= {sr[6:0], 1'b0}; sda_oe_o <= !sr[6];
              end
            end
          end
          S_MACK: if (scl_rise_i) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_sec_checker.sv
module smb_sec_checker
  import smb_info_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] sec_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          valid_o,
  output logic          absent_o
);
  chk_st_e    st;
  logic [7:0] sum, rem;

  assign busy_o = (st != C_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= C_IDLE;
      sum       <= '0;
      rem       <= '0;
      rd_addr_o <= '0;
      done_o    <= 1'b0;
      valid_o   <= 1'b0;
      absent_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        C_IDLE: if (start_i) begin
          rd_addr_o <= AW'(HDR_PTR0) + AW'(sec_i);
          valid_o   <= 1'b0;
          absent_o  <= 1'b0;
          st        <= C_PTR;
        end
        C_PTR: begin
          if (rd_data_i == 8'h00) begin
            absent_o <= 1'b1; done_o <= 1'b1; st <= C_IDLE;
          end else begin
            rd_addr_o <= AW'(rd_data_i); st <= C_LEN;
          end
        end
        C_LEN: begin
          rem <= rd_data_i; sum <= '0;
          rd_addr_o <= rd_addr_o + AW'(1);
          st <= C_SUM;
        end
        C_SUM: begin
          sum       <= sum + rd_data_i;
          rd_addr_o <= rd_addr_o + AW'(1);
          if (rem == 8'h00) begin
            valid_o <= (8'(sum + rd_data_i) == 8'h00);
            done_o  <= 1'b1;
            st      <= C_IDLE;
          end else begin
            rem <= rem - 8'h01;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_info_rom.sv
module smb_info_rom
  import smb_info_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  input  logic          chk_start_i,
  input  logic [SW-1:0] chk_sec_i,
  output logic          chk_busy_o,
  output logic          chk_done_o,
  output logic          chk_valid_o,
  output logic          chk_absent_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          we;
  logic [7:0]    wdata, a_data, b_data;
  logic [AW-1:0] offset, b_addr;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_target_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .strap_i, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(a_data), .offset_o(offset), .we_o(we), .wdata_o(wdata),
    .sda_oe_o
  );

  smb_info_mem #(.AW(AW), .ROM_D(ROM_DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(offset), .wdata_i(wdata),
    .a_addr_i(offset), .a_data_o(a_data),
    .b_addr_i(b_addr), .b_data_o(b_data)
  );

  smb_sec_checker #(.AW(AW), .SW(SW)) u_chk (
    .clk_i, .rst_ni, .start_i(chk_start_i), .sec_i(chk_sec_i),
    .rd_addr_o(b_addr), .rd_data_i(b_data),
    .busy_o(chk_busy_o), .done_o(chk_done_o),
    .valid_o(chk_valid_o), .absent_o(chk_absent_o)
  );
endmodule

// File: rtl/smb_info_rom_sva.sv
module smb_info_rom_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic chk_start_i,
  input logic chk_busy_o,
  input logic chk_done_o,
  input logic chk_valid_o,
  input logic chk_absent_o,
  input logic start_det
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);  // R9
  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);  // R5
  AST_START_GOES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_start_i && !chk_busy_o |=> chk_busy_o);  // R7
  AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chk_busy_o) |-> chk_done_o);  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_done_o |=> !chk_done_o);  // R7
  AST_ABSENT_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_absent_o |-> !chk_valid_o);  // R8
endmodule

bind smb_info_rom smb_info_rom_sva u_sva (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .chk_start_i,
  .chk_busy_o, .chk_done_o, .chk_valid_o, .chk_absent_o,
  .start_det(start_det)
);

// File: tb/sim_smb_info_rom.sv
module sim_smb_info_rom;
  localparam int Q = 10;  // clocks per quarter of SCL activity

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [2:0] strap = 3'b101;
  logic chk_start = 1'b0;
  logic [1:0] chk_sec = '0;
  logic chk_busy, chk_done, chk_valid, chk_absent;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz
  assign sda_line = sda_m & ~sda_oe;

  smb_info_rom u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap),
    .chk_start_i(chk_start), .chk_sec_i(chk_sec),
    .chk_busy_o(chk_busy), .chk_done_o(chk_done),
    .chk_valid_o(chk_valid), .chk_absent_o(chk_absent)
  );

  typedef struct packed {
    logic       wr;
    logic [6:0] dev;
    logic [7:0] off;
    logic [7:0] dat;
    logic       ack;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'h55, 8'h00, 8'h00, 1'b1, 8'h01},
    '{1'b0, 7'h55, 8'h01, 8'h00, 1'b1, 8'h10},
    '{1'b0, 7'h55, 8'h03, 8'h00, 1'b1, 8'h80},
    '{1'b0, 7'h55, 8'h14, 8'h00, 1'b1, 8'hB6},
    '{1'b0, 7'h55, 8'h25, 8'h00, 1'b1, 8'h56},
    '{1'b1, 7'h55, 8'h90, 8'hA5, 1'b1, 8'h00},
    '{1'b0, 7'h55, 8'h90, 8'h00, 1'b1, 8'hA5},
    '{1'b1, 7'h55, 8'hFF, 8'h3C, 1'b1, 8'h00},
    '{1'b0, 7'h55, 8'hFF, 8'h00, 1'b1, 8'h3C},
    '{1'b1, 7'h55, 8'h7F, 8'h12, 1'b1, 8'h00},
    '{1'b0, 7'h55, 8'h7F, 8'h00, 1'b1, 8'hFF},
    '{1'b1, 7'h55, 8'h11, 8'h00, 1'b1, 8'h00},
    '{1'b0, 7'h55, 8'h11, 8'h00, 1'b1, 8'hAA},
    '{1'b1, 7'h54, 8'h91, 8'h77, 1'b0, 8'h00}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 3, 4: return "R6";
      5, 6, 7, 8:    return "R2";
      13:            return "R1";
      default:       return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = !sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic oe_at_nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); scl_m = 1'b1; wq(); oe_at_nack = sda_oe; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] off, input logic [7:0] d,
                          output logic [2:0] acks);
    logic a;
    bus_start();
    send_byte({dev, 1'b0}, a); acks[2] = a;
    send_byte(off, a);         acks[1] = a;
    send_byte(d, a);           acks[0] = a;
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] off, output logic [7:0] d,
                         output logic ack_ok, output logic oe_nack);
    logic a0, a1, a2;
    bus_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(off, a1);
    bus_start();
    send_byte({dev, 1'b1}, a2);
    recv_byte(d, oe_nack);
    bus_stop();
    ack_ok = a0 & a1 & a2;
  endtask

  task automatic run_chk(input logic [1:0] sec, input logic ev, input logic ea, input string tag);
    int t;
    @(negedge clk); chk_sec = sec; chk_start = 1'b1;
    @(negedge clk); chk_start = 1'b0;
    check(chk_busy == 1'b1, tag, chk_busy, 1);
    t = 0;
    while (!chk_done && t < 2000) begin @(negedge clk); t++; end
    check(chk_done == 1'b1, tag, chk_done, 1);
    check(chk_valid == ev && chk_absent == ea, tag, {chk_valid, chk_absent}, {ev, ea});
    @(negedge clk);
    check(chk_done == 1'b0 && chk_busy == 1'b0, tag, chk_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0] acks;
    logic ok, oe_n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    check({chk_busy, chk_done, chk_valid, chk_absent} == 4'b0, "R10 checker",
          {chk_busy, chk_done, chk_valid, chk_absent}, 0);
    do_read(7'h55, 8'hC0, d, ok, oe_n);
    check(ok && d == 8'h00, "R10 scratch zero", d, 0);

    // R7 sections in image, zero scratch section; R8 absent
    run_chk(2'd0, 1'b1, 1'b0, "R7 sec0");
    run_chk(2'd1, 1'b1, 1'b0, "R7 sec1");
    run_chk(2'd2, 1'b1, 1'b0, "R7 empty scratch sec");
    run_chk(2'd3, 1'b0, 1'b1, "R8 absent sec3");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        do_write(VEC[i].dev, VEC[i].off, VEC[i].dat, acks);
        if (VEC[i].ack) check(acks == 3'b111, vec_tag(i), acks, 7);
        else            check(acks[2] == 1'b0, vec_tag(i), acks[2], 0);
      end else begin
        do_read(VEC[i].dev, VEC[i].off, d, ok, oe_n);
        check(ok == VEC[i].ack, vec_tag(i), ok, VEC[i].ack);
        check(d == VEC[i].exp, vec_tag(i), d, VEC[i].exp);
        check(oe_n == 1'b0, "R4 released at NACK", oe_n, 0);
      end
    end
    // R1 mismatched write left scratch untouched
    do_read(7'h55, 8'h91, d, ok, oe_n);
    check(d == 8'h00, "R1 no store on mismatch", d, 0);

    // R1 strap change moves the address
    strap = 3'b010;
    do_read(7'h52, 8'h10, d, ok, oe_n);
    check(ok && d == 8'h03, "R1 new strap", d, 3);
    do_read(7'h55, 8'h10, d, ok, oe_n);
    check(ok == 1'b0, "R1 old address nacked", ok, 0);
    check(sda_oe == 1'b0, "R1 idle after mismatch", sda_oe, 0);
    strap = 3'b101;

    // R5 STOP in mid data byte: nothing stored
    bus_start(); send_byte({7'h55, 1'b0}, ok); send_byte(8'h85, ok);
    send_bits(8'hE7, 4); bus_stop();
    do_read(7'h55, 8'h85, d, ok, oe_n);
    check(ok && d == 8'h00, "R5 stop abort", d, 0);

    // R5 repeated START after 3 address bits restarts the byte
    bus_start(); send_bits(8'hA0, 3); bus_start();
    send_byte({7'h55, 1'b0}, acks[2]); send_byte(8'h86, acks[1]); send_byte(8'h5A, acks[0]);
    bus_stop();
    check(acks == 3'b111, "R5 restart acks", acks, 7);
    do_read(7'h55, 8'h86, d, ok, oe_n);
    check(d == 8'h5A, "R5 restart data", d, 8'h5A);

    // R7 scratch section: 02 10 20 D0 sums to zero, then corrupt
    do_write(7'h55, 8'h80, 8'h02, acks);
    do_write(7'h55, 8'h81, 8'h10, acks);
    do_write(7'h55, 8'h82, 8'h20, acks);
    do_write(7'h55, 8'h83, 8'hD0, acks);
    run_chk(2'd2, 1'b1, 1'b0, "R7 good scratch sec");
    do_write(7'h55, 8'h83, 8'hD1, acks);
    run_chk(2'd2, 1'b0, 1'b0, "R7 bad scratch sec");

    // R9 bus idle leaves line released
    check(sda_oe == 1'b0, "R9 released when idle", sda_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule